// File: doc/BRIEF.md
# Programmable 8-bit Timer/Counter Core

This block is an 8-bit up-counter whose advance is gated by a selectable timer tick. The tick is drawn from a free-running internal prescaler (undivided, or divided by 8, 64, 256 or 1024) or from an external count pin. The pin is first brought into the clock domain by a two-flop synchronizer and then reduced to one-cycle pulses on its rising or falling edges. A clock-select value of zero stops the count.

A mode bit picks the turnaround point. In free-run mode the counter wraps after 0xFF. In match mode it clears after reaching a programmable compare value. Software can load the count at any time, and that load overrides any tick in the same cycle. The tick that turns the counter around also sets a sticky overflow flag. The flag drives the interrupt request and stays set until software strobes a clear.

Top module: `tmr8_core`

## Requirements
- R1: Each timer tick that is not overridden by a count load moves `cnt_o` up by one, one cycle after the tick, unless the count equals the active TOP; in that case the next value is zero. A count above TOP moves up through 0xFF and wraps to zero.
- R2: With the clock select at 0 and no count load, `cnt_o` holds its value on every cycle.
- R3: A pulse on `wr_cnt_i` loads `wr_data_i` into the count. The loaded value appears on `cnt_o` one cycle later for any clock-select value, including 0.
- R4: A count load in the same cycle as a tick wins. The tick's increment or clear is discarded, and so is the overflow-flag set it would have caused.
- R5: A pulse on `wr_ctl_i` stores `wr_data_i[2:0]` as the clock select and `wr_data_i[3]` as the mode bit. A pulse on `wr_cmp_i` stores `wr_data_i` as the compare value. Mode 0 uses TOP = 0xFF. Mode 1 uses TOP = the compare value.
- R6: A tick taken while the count equals TOP sets `ovf_o` one cycle later, and `irq_o` always equals `ovf_o`.
- R7: `ovf_o` stays set until a `flag_clr_i` pulse clears it one cycle later. If the flag is set and cleared in the same cycle, the set wins.
- R8: The prescaler is a 10-bit counter that starts at zero when reset is released and moves up by one every cycle. Clock select 1 ticks every cycle. Selects 2, 3, 4 and 5 tick only in cycles where the low 3, 6, 8 or 10 prescaler bits are all ones.
- R9: Select 7 counts rising edges of `ext_pin_i` and select 6 counts falling edges, each giving one tick. A pin change set up before a clock edge changes `cnt_o` after the third edge.
- R10: While reset is asserted and right after it is released, the count, clock select, mode bit, compare value and flag are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ext_pin_i | input | 1 | External count pin, asynchronous |
| wr_cnt_i | input | 1 | Load count from `wr_data_i` |
| wr_ctl_i | input | 1 | Load clock select (bits 2:0) and mode (bit 3) |
| wr_cmp_i | input | 1 | Load compare value from `wr_data_i` |
| wr_data_i | input | 8 | Write data shared by the three load strobes |
| flag_clr_i | input | 1 | One-cycle overflow-flag clear |
| cnt_o | output | 8 | Current count |
| ovf_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Interrupt request, follows the flag |

## Verification
Directed runs start with the undivided clock near 0xFF and then a small compare value in match mode; these separate a wrap at 0xFF from a clear at the compare value, and show when the flag is set. Prescaler runs at 8, 64, 256 and 1024 show whether the tick phase comes from a free-running counter, and whether each division picks the right low bits. Pin toggling under both edge selects shows the synchronizer latency and single-edge counting. Finally, a random mix of loads, control rewrites, clears and pin activity lands a load or a clear on the same cycle as a turnaround tick, which exposes any error in priority.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

  localparam int CNT_W = 8;
  localparam int PRE_W = 10;

  typedef enum logic [2:0] {
    CS_OFF      = 3'd0,
    CS_DIV1     = 3'd1,
    CS_DIV8     = 3'd2,
    CS_DIV64    = 3'd3,
    CS_DIV256   = 3'd4,
    CS_DIV1024  = 3'd5,
    CS_EXT_FALL = 3'd6,
    CS_EXT_RISE = 3'd7
  } clk_sel_e;

  // number of low prescaler bits that must all be one for a tick
  function automatic int div_bits(input clk_sel_e cs);
    case (cs)
      CS_DIV8:    return 3;
      CS_DIV64:   return 6;
      CS_DIV256:  return 8;
      CS_DIV1024: return 10;
      default:    return 0;
    endcase
  endfunction

  function automatic logic pre_hit(input logic [PRE_W-1:0] pre, input int k);
    logic [PRE_W-1:0] m;
    m = '0;
    for (int i = 0; i < PRE_W; i++) begin
      if (i < k) m[i] = 1'b1;
    end
    return (pre & m) == m;
  endfunction

  function automatic logic [CNT_W-1:0] top_of(input logic mode,
                                               input logic [CNT_W-1:0] cmp);
    return mode ? cmp : {CNT_W{1'b1}};
  endfunction

  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] cnt,
                                                input logic [CNT_W-1:0] top);
    return (cnt == top) ? '0 : cnt + CNT_W'(1);
  endfunction

endpackage

// File: rtl/tmr8_prescaler.sv
module tmr8_prescaler #(
  parameter int PRE_W = tmr8_pkg::PRE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [PRE_W-1:0] pre_o
);
  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_q + PRE_W'(1);
  end

  assign pre_o = pre_q;
endmodule

// File: rtl/tmr8_pin_edge.sv
module tmr8_pin_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  if (STAGES == 1) begin : g_one
    always_ff @(posedge clk_i) begin
      if (!rst_ni) sync_q <= '0;
      else         sync_q <= pin_i;
    end
  end else begin : g_chain
    always_ff @(posedge clk_i) begin
      if (!rst_ni) sync_q <= '0;
      else         sync_q <= {sync_q[STAGES-2:0], pin_i};
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/tmr8_count.sv
module tmr8_count
  import tmr8_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] top_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             wrap_w;

  assign wrap_w = tick_i & ~load_i & (cnt_q == top_i);

  always_ff @(posedge clk_i) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (load_i)  cnt_q <= load_val_i;
    else if (tick_i)  cnt_q <= cnt_step(cnt_q, top_i);
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)      ovf_q <= 1'b0;
    else if (wrap_w)  ovf_q <= 1'b1;
    else if (clr_i)   ovf_q <= 1'b0;
  end

  assign cnt_o  = cnt_q;
  assign ovf_o  = ovf_q;
  assign wrap_o = wrap_w;
endmodule

// File: rtl/tmr8_core.sv
module tmr8_core
  import tmr8_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_pin_i,
  input  logic             wr_cnt_i,
  input  logic             wr_ctl_i,
  input  logic             wr_cmp_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o,
  output logic             irq_o
);
  clk_sel_e         csel_q;
  logic             mode_q;
  logic [CNT_W-1:0] cmp_q;
  logic [PRE_W-1:0] pre_w;
  logic             ext_rise_w;
  logic             ext_fall_w;
  logic             tick_w;
  logic             timer_off_w;
  logic [CNT_W-1:0] top_w;
  logic             wrap_w;
  logic [CNT_W-1:0] cnt_w;
  logic             ovf_w;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      csel_q <= CS_OFF;
      mode_q <= 1'b0;
    end else if (wr_ctl_i) begin
      csel_q <= clk_sel_e'(wr_data_i[2:0]);
      mode_q <= wr_data_i[3];
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)       cmp_q <= '0;
    else if (wr_cmp_i) cmp_q <= wr_data_i;
  end

  tmr8_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pre_o  (pre_w)
  );

  tmr8_pin_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (ext_pin_i),
    .rise_o (ext_rise_w),
    .fall_o (ext_fall_w)
  );

  always_comb begin
    case (csel_q)
      CS_OFF:      tick_w = 1'b0;
      CS_EXT_FALL: tick_w = ext_fall_w;
      CS_EXT_RISE: tick_w = ext_rise_w;
      default:     tick_w = pre_hit(pre_w, div_bits(csel_q));
    endcase
  end

  assign timer_off_w = (csel_q == CS_OFF);
  assign top_w       = top_of(mode_q, cmp_q);

  tmr8_count u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_w),
    .top_i      (top_w),
    .load_i     (wr_cnt_i),
    .load_val_i (wr_data_i),
    .clr_i      (flag_clr_i),
    .cnt_o      (cnt_w),
    .ovf_o      (ovf_w),
    .wrap_o     (wrap_w)
  );

  assign cnt_o = cnt_w;
  assign ovf_o = ovf_w;
  assign irq_o = ovf_w;
endmodule

// File: rtl/tmr8_chk.sv
module tmr8_chk
  import tmr8_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick,
  input logic             timer_off,
  input logic             wr_cnt,
  input logic [CNT_W-1:0] wr_data,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] top,
  input logic             wrap,
  input logic             ovf,
  input logic             clr,
  input logic             ext_rise,
  input logic             ext_fall
);
  AST_STEP_BY_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !wr_cnt && cnt != top) |=> cnt == $past(cnt) + CNT_W'(1)); // R1
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timer_off && !wr_cnt) |=> $stable(cnt)); // R2
  AST_CPU_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt |=> cnt == $past(wr_data)); // R4
  AST_CLEAR_AT_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !wr_cnt && cnt == top) |=> cnt == '0); // R5
  AST_FLAG_ON_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> ovf); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf && !clr) |=> ovf); // R7
  AST_EXT_RISE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_rise |=> !ext_rise); // R9
  AST_EXT_FALL_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_fall |=> !ext_fall); // R9
endmodule

bind tmr8_core tmr8_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick      (tick_w),
  .timer_off (timer_off_w),
  .wr_cnt    (wr_cnt_i),
  .wr_data   (wr_data_i),
  .cnt       (cnt_o),
  .top       (top_w),
  .wrap      (wrap_w),
  .ovf       (ovf_o),
  .clr       (flag_clr_i),
  .ext_rise  (ext_rise_w),
  .ext_fall  (ext_fall_w)
);

// File: tb/tmr8_core_tb_top.sv
module tmr8_core_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin = 1'b0;
  logic       wr_cnt = 1'b0, wr_ctl = 1'b0, wr_cmp = 1'b0, clr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] cnt;
  logic       ovf, irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model state
  int m_cnt = 0, m_sel = 0, m_mode = 0, m_cmp = 0, m_ovf = 0, m_pre = 0;
  int m_s1 = 0, m_s2 = 0, m_s3 = 0;

  always #2 clk = ~clk;

  tmr8_core dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ext_pin_i(pin),
    .wr_cnt_i(wr_cnt), .wr_ctl_i(wr_ctl), .wr_cmp_i(wr_cmp),
    .wr_data_i(wdata), .flag_clr_i(clr),
    .cnt_o(cnt), .ovf_o(ovf), .irq_o(irq)
  );

  function automatic int f_top(int mode, int cmp);
    if (mode != 0) return cmp;
    return 255;
  endfunction

  function automatic int f_period(int sel);
    case (sel)
      1: return 1;
      2: return 8;
      3: return 64;
      4: return 256;
      5: return 1024;
      default: return 0;
    endcase
  endfunction

  function automatic bit f_tick(int sel, int pre, int s2, int s3);
    if (sel == 0) return 1'b0;
    if (sel == 7) return (s2 == 1) && (s3 == 0);
    if (sel == 6) return (s2 == 0) && (s3 == 1);
    return (pre % f_period(sel)) == f_period(sel) - 1;
  endfunction

  task automatic model_edge();
    bit tk;
    int tp;
    bit wrap;
    tk = f_tick(m_sel, m_pre, m_s2, m_s3);
    tp = f_top(m_mode, m_cmp);
    wrap = tk && !wr_cnt && (m_cnt == tp);
    if (wr_cnt) m_cnt = int'(wdata);
    else if (tk) m_cnt = wrap ? 0 : (m_cnt + 1) % 256;
    if (wrap) m_ovf = 1;
    else if (clr) m_ovf = 0;
    if (wr_ctl) begin
      m_sel  = int'(wdata) % 8;
      m_mode = (int'(wdata) / 8) % 2;
    end
    if (wr_cmp) m_cmp = int'(wdata);
    m_s3 = m_s2;
    m_s2 = m_s1;
    m_s1 = int'(pin);
    m_pre = (m_pre + 1) % 1024;
  endtask

  task automatic check(string tag);
    checks++;
    if (int'(cnt) != m_cnt) begin
      fails++;
      $display("FAIL %s cnt_o act=%0d exp=%0d", tag, cnt, m_cnt);
    end
    checks++;
    if (int'(ovf) != m_ovf) begin
      fails++;
      $display("FAIL %s ovf_o act=%0d exp=%0d", tag, ovf, m_ovf);
    end
    checks++;
    if (irq !== ovf) begin
      fails++;
      $display("FAIL R6 irq_o act=%0d exp=%0d", irq, ovf);
    end
  endtask

  // inputs already set after a falling edge; advance one cycle and check
  task automatic step(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(tag);
    wr_cnt = 1'b0; wr_ctl = 1'b0; wr_cmp = 1'b0; clr = 1'b0;
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic set_ctl(int sel, int mode, string tag);
    wr_ctl = 1'b1;
    wdata = 8'(mode * 8 + sel);
    step(tag);
  endtask

  task automatic load(int v, string tag);
    wr_cnt = 1'b1;
    wdata = 8'(v);
    step(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    check("R10");
    rst_n = 1'b1;
    check("R10");

    run(5, "R2");
    load(8'h5A, "R3");
    run(3, "R2");

    set_ctl(1, 0, "R1");
    load(8'hFC, "R3");
    run(6, "R6");
    clr = 1'b1;
    step("R7");
    run(2, "R1");

    // match mode with compare 5
    wr_ctl = 1'b1; wr_cmp = 1'b1; wr_cnt = 1'b1; wdata = 8'h09;
    step("R5");
    wr_cmp = 1'b1; wdata = 8'd5; wr_cnt = 1'b1;
    step("R5");
    run(14, "R5");
    clr = 1'b1;
    step("R7");

    // load while sitting at TOP: tick and flag set discarded
    load(5, "R3");
    load(8'h33, "R4");
    run(2, "R4");
    load(5, "R3");
    clr = 1'b1;
    load(5, "R4");

    // set and clear together
    for (int i = 0; i < 20; i++) begin
      clr = (m_cnt == f_top(m_mode, m_cmp));
      step("R7");
    end

    // compare below current count: wraps via 0xFF
    load(8'hF0, "R1");
    run(20, "R1");

    // prescaler divisions
    set_ctl(2, 0, "R8");
    run(100, "R8");
    set_ctl(3, 0, "R8");
    run(300, "R8");
    set_ctl(4, 0, "R8");
    run(700, "R8");
    set_ctl(5, 0, "R8");
    run(2200, "R8");

    // external edges
    set_ctl(7, 0, "R9");
    for (int i = 0; i < 16; i++) begin
      pin = ~pin;
      run(5, "R9");
    end
    set_ctl(6, 0, "R9");
    for (int i = 0; i < 16; i++) begin
      pin = ~pin;
      run(3, "R9");
    end
    set_ctl(0, 0, "R2");
    for (int i = 0; i < 6; i++) begin
      pin = ~pin;
      run(3, "R2");
    end

    // random mix
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 4 == 0) pin = ~pin;
      wdata  = 8'($urandom);
      wr_cnt = ($urandom % 32 == 0);
      wr_ctl = ($urandom % 64 == 0);
      wr_cmp = ($urandom % 64 == 0);
      clr    = ($urandom % 16 == 0);
      if (wr_ctl && ($urandom % 4 != 0)) wdata[2:0] = 3'd1;
      step("R1");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule